// File: doc/BRIEF.md
# SMBus indexed block-access register slave

This block is an SMBus target that lets a host reach a 32-byte register file inside the chip. Every transaction begins with the write address D2h and a register offset byte. The offset sets the location where the data transfer starts. Writes carry a count byte that sets how many data bytes follow. Reads use a repeated start and the read address D3h. The target then returns a count byte from a programmable read-count register at location 8, followed by that many data bytes.

The top bit of the count byte in a write selects the mode. When it is clear, the block performs a normal block write. When it is set, the low seven bits are loaded into the read-count register. The host then issues a repeated start with D3h, so one transaction both sets the read length and performs the read. The register contents are also presented in parallel to the rest of the chip.

SCL and SDA arrive through two-flop synchronizers and a short glitch filter. SDA is only ever pulled low, through an output enable.

Top module: `smb_index_target`

## Requirements
- R1: After reset every register reads 00h except register 8, which reads 0Fh, and SDA is not driven.
- R2: Only the address bytes D2h and D3h are acknowledged. Any other address byte gets a NACK (SDA high in the ninth bit), and the rest of that transaction is ignored.
- R3: In a block write (D2h, offset, count N with bit 7 = 0, N data bytes), every byte is ACKed (SDA low in the ninth bit), and the data lands at offset, offset+1, and so on.
- R4: A write count byte of 00h is NACKed, and no data byte that follows it is written.
- R5: Data bytes sent beyond the count N are NACKed and not written.
- R6: A count byte with bit 7 = 1 is ACKed. Its low seven bits are stored into register 8 with bit 7 cleared, and no data register is written.
- R7: After D2h, an offset and a repeated start with D3h, the target returns the value of register 8 first. It then returns the bytes from the offset upward, as long as the host ACKs.
- R8: The register pointer wraps from 31 to 0, on both writes and reads.
- R9: A normal block write to register 8 changes the count returned by later reads.
- R10: A start or stop that arrives inside a data byte aborts the transfer. Bytes completed earlier stay written, and the partial byte is discarded.
- R11: After the host NACKs a read byte, the target releases SDA and drives nothing until the next start or stop.
- R12: SDA is driven only low, and the output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line from the pad, asynchronous |
| sda_in | input | 1 | SDA line from the pad, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_view | output | 256 | Register contents; byte i at bits [8i+7:8i] |

## Verification
The hardest case to reach from the pins is an abort inside a byte: a stop must arrive after only a few data bits, once earlier bytes of the same write have already been committed. The bench's bit-level master can clock out a chosen number of bits and then issue a stop at once. The bench then checks through the parallel register view that the committed byte survived and that the next location was left untouched. The released-bus state after an early host NACK is reached in a similar way. The master keeps clocking a read byte after its NACK and expects all ones on the wired-AND bus.

// File: rtl/smbx_pkg.sv
// Shared types and constants for the indexed SMBus register target.
package smbx_pkg;
    localparam logic [7:0] ADDR_WR = 8'hD2;
    localparam logic [7:0] ADDR_RD = 8'hD3;

    // Bit-level phase of the target.
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_WAIT
    } st_t;

    // Meaning of the next received byte.
    typedef enum logic [2:0] {
        K_ADDR, K_OFFS, K_CNT, K_DATA, K_NONE
    } kind_t;
endpackage

// File: rtl/smbx_filt.sv
// Synchronizer plus glitch filter for one bus line.
// Assumes an idle-high line; the output only moves after FILT equal samples.
module smbx_filt #(
    parameter int SYNC = 2,
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [SYNC-1:0] sync_q;
    logic [FILT-1:0] hist_q;

    // Synchronizer chain and filter history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], din};
            hist_q <= {hist_q[FILT-2:0], sync_q[SYNC-1]};
        end
    end

    // Filtered output follows only a unanimous history.
    always_ff @(posedge clk) begin
        if (!rst_n)               dout <= 1'b1;
        else if (&hist_q)         dout <= 1'b1;
        else if (~|hist_q)        dout <= 1'b0;
    end
endmodule

// File: rtl/smbx_regfile.sv
// Byte-wide register file with a single write port and one read port.
// Location CNT_IDX resets to CNT_RST and is also exported as the read count.
module smbx_regfile #(
    parameter int         REGS    = 32,
    parameter int         AW      = 5,
    parameter int         CNT_IDX = 8,
    parameter logic [7:0] CNT_RST = 8'h0F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data,
    output logic [7:0]      cnt_val,
    output logic [REGS*8-1:0] view
);
    logic [7:0] reg_q [REGS];

    for (genvar i = 0; i < REGS; i++) begin : g_reg
        // One register: reset value, then written on address match.
        always_ff @(posedge clk) begin
            if (!rst_n)
                reg_q[i] <= (i == CNT_IDX) ? CNT_RST : 8'h00;
            else if (wr_en && wr_addr == AW'(i))
                reg_q[i] <= wr_data;
        end
        assign view[i*8 +: 8] = reg_q[i];
    end

    assign rd_data = reg_q[rd_addr];
    assign cnt_val = reg_q[CNT_IDX];
endmodule

// File: rtl/smbx_ctrl.sv
// Bit and byte sequencer of the target: start/stop detection, address match,
// ACK generation, block write, count-register load and block read.
// Assumes filtered SCL/SDA; SDA output changes only on a detected SCL fall.
module smbx_ctrl
    import smbx_pkg::*;
#(
    parameter int AW      = 5,
    parameter int CNT_IDX = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_f,
    input  logic          sda_f,
    input  logic [7:0]    rd_data,
    input  logic [7:0]    cnt_val,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] rd_addr
);
    logic scl_q, sda_q;
    logic scl_rise, scl_fall, start_c, stop_c;
    st_t st;
    kind_t kind;
    logic [3:0] bcnt;
    logic [7:0] shreg, txbyte, remain;
    logic [AW-1:0] ptr;
    logic to_tx, mack;
    logic dec_ack, dec_tx, dec_wr;
    kind_t dec_kind;

    // Previous filtered line levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

    // Decision for a completed received byte.
    always_comb begin
        dec_ack  = 1'b0;
        dec_tx   = 1'b0;
        dec_wr   = 1'b0;
        dec_kind = K_NONE;
        wr_addr  = ptr;
        wr_data  = shreg;
        case (kind)
            K_ADDR: begin
                if (shreg == ADDR_WR) begin
                    dec_ack  = 1'b1;
                    dec_kind = K_OFFS;
                end else if (shreg == ADDR_RD) begin
                    dec_ack = 1'b1;
                    dec_tx  = 1'b1;
                end
            end
            K_OFFS: begin
                dec_ack  = 1'b1;
                dec_kind = K_CNT;
            end
            K_CNT: begin
                if (shreg[7]) begin
                    dec_ack = 1'b1;
                    dec_wr  = 1'b1;
                    wr_addr = AW'(CNT_IDX);
                    wr_data = {1'b0, shreg[6:0]};
                end else if (shreg != 8'h00) begin
                    dec_ack  = 1'b1;
                    dec_kind = K_DATA;
                end
            end
            K_DATA: begin
                dec_ack  = 1'b1;
                dec_wr   = 1'b1;
                dec_kind = (remain == 8'd1) ? K_NONE : K_DATA;
            end
            default: ;
        endcase
    end

    assign wr_en   = (st == ST_RX) && scl_fall && (bcnt == 4'd8) && dec_wr;
    assign rd_addr = ptr;

    // Main sequencer: conditions first, then per-phase bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            kind   <= K_ADDR;
            bcnt   <= '0;
            shreg  <= '0;
            txbyte <= '0;
            remain <= '0;
            ptr    <= '0;
            to_tx  <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_c) begin
            st     <= ST_RX;
            kind   <= K_ADDR;
            bcnt   <= '0;
            to_tx  <= 1'b0;
            sda_oe <= 1'b0;
        end else if (stop_c) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (scl_rise && bcnt < 4'd8) begin
                        shreg <= {shreg[6:0], sda_f};
                        bcnt  <= bcnt + 4'd1;
                    end else if (scl_fall && bcnt == 4'd8) begin
                        if (dec_ack) begin
                            sda_oe <= 1'b1;
                            st     <= ST_RXACK;
                            kind   <= dec_kind;
                            to_tx  <= dec_tx;
                            if (kind == K_OFFS) ptr <= shreg[AW-1:0];
                            if (kind == K_CNT) remain <= shreg;
                            if (kind == K_DATA) begin
                                ptr    <= ptr + 1'b1;
                                remain <= remain - 8'd1;
                            end
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                ST_RXACK: begin
                    if (scl_fall) begin
                        bcnt <= '0;
                        if (to_tx) begin
                            txbyte <= cnt_val;
                            sda_oe <= ~cnt_val[7];
                            bcnt   <= 4'd1;
                            st     <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bcnt < 4'd8) begin
                            txbyte <= {txbyte[6:0], 1'b0};
                            sda_oe <= ~txbyte[6];
                            bcnt   <= bcnt + 4'd1;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_TXACK;
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_f;
                    end else if (scl_fall) begin
                        if (mack) begin
                            txbyte <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr + 1'b1;
                            bcnt   <= 4'd1;
                            st     <= ST_TX;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smb_index_target.sv
// Top of the indexed SMBus register target: filters the bus lines,
// sequences transfers and holds the register file.
// Assumes an external open-drain pad driven low when sda_oe is 1.
module smb_index_target #(
    parameter int         REGS    = 32,
    parameter int         SYNC    = 2,
    parameter int         FILT    = 3,
    parameter int         CNT_IDX = 8,
    parameter logic [7:0] CNT_RST = 8'h0F,
    localparam int        AW      = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [REGS*8-1:0] reg_view
);
    logic [1:0] raw_lines, flt_lines;
    logic scl_f, sda_f;
    logic wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data, cnt_val;

    assign raw_lines = {scl_in, sda_in};

    for (genvar i = 0; i < 2; i++) begin : g_line
        smbx_filt #(.SYNC(SYNC), .FILT(FILT)) filt_i (
            .clk(clk), .rst_n(rst_n), .din(raw_lines[i]), .dout(flt_lines[i])
        );
    end

    assign scl_f = flt_lines[1];
    assign sda_f = flt_lines[0];

    smbx_ctrl #(.AW(AW), .CNT_IDX(CNT_IDX)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .rd_data(rd_data), .cnt_val(cnt_val), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr)
    );

    smbx_regfile #(.REGS(REGS), .AW(AW), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)) rf_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_val(cnt_val), .view(reg_view)
    );
endmodule

// File: rtl/smbx_checker.sv
// Property checker for the indexed SMBus target, bound to its top.
module smbx_checker #(
    parameter int         REGS    = 32,
    parameter int         CNT_IDX = 8,
    parameter logic [7:0] CNT_RST = 8'h0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_f,
    input logic              sda_f,
    input logic              wr_en,
    input logic [REGS*8-1:0] reg_view
);
    // R1: one reset cycle leaves the count register at its reset value and SDA released.
    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> (reg_view[CNT_IDX*8 +: 8] == CNT_RST) && !sda_oe);

    // R12: the output enable moves only while filtered SCL is low.
    p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

    // R10: registers change only on a write strobe.
    p_view_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_view));

    // R11: a stop condition leaves SDA released.
    p_release_on_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && sda_f && !$past(sda_f)) |=> !sda_oe);
endmodule

bind smb_index_target smbx_checker #(.REGS(REGS), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)) chk_i (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_f(scl_f),
    .sda_f(sda_f), .wr_en(wr_en), .reg_view(reg_view)
);

// File: tb/smb_index_target_tb_top.sv
// Scoreboard bench: bus tasks queue expected ACKs and bytes, a monitor compares.
module smb_index_target_tb_top;
    localparam int REGS = 32;
    localparam int Q    = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [REGS*8-1:0] reg_view;
    wire  sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    int oe_bad = 0;
    bit done   = 0;

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    logic [7:0] obs_val;
    event obs_ev;
    logic [7:0] model [REGS];

    always #10 clk = ~clk;

    smb_index_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_oe(sda_oe), .reg_view(reg_view)
    );

    // Monitor: pops one expected item per observed bus result.
    always @(obs_ev) begin
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL scoreboard: unexpected item %02h", obs_val);
        end else begin
            e = exp_q.pop_front();
            if (obs_val !== e.val) begin
                fails++;
                $display("FAIL %s: got %02h expected %02h", e.tag, obs_val, e.val);
            end
        end
    end

    // R12 bench monitor: enable must not move while raw SCL is high.
    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_m) oe_bad++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic v);
        sda_m = v; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output logic v);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); v = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    // Driver: send a byte and queue the expected acknowledge (1 = ACK).
    task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
        logic s;
        exp_q.push_back('{{7'd0, exp_ack}, tag});
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(s);
        obs_val = {7'd0, ~s};
        -> obs_ev;
    endtask

    // Driver: clock in a byte, queue its expected value, then ACK or NACK.
    task automatic recv(input logic last, input logic [7:0] expv, input string tag);
        logic v;
        logic [7:0] b;
        exp_q.push_back('{expv, tag});
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            b[i] = v;
        end
        put_bit(last);
        obs_val = b;
        -> obs_ev;
    endtask

    function automatic logic [7:0] rv(input int i);
        return reg_view[i*8 +: 8];
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < REGS; i++) model[i] = 8'h00;
        model[8] = 8'h0F;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1: reset values and released SDA.
        for (int i = 0; i < REGS; i++) chk(rv(i), model[i], "R1 reset value");
        chk({7'd0, sda_oe}, 8'h00, "R1 sda released");

        // R3: block write of four bytes at offset 3.
        bus_start();
        send(8'hD2, 1, "R2 write address");
        send(8'h03, 1, "R3 offset");
        send(8'h04, 1, "R3 count");
        for (int i = 0; i < 4; i++) begin
            send(8'hA1 + 8'(i), 1, "R3 data ack");
            model[3+i] = 8'hA1 + 8'(i);
        end
        bus_stop();
        for (int i = 3; i < 7; i++) chk(rv(i), model[i], "R3 written data");

        // R7: indexed read with default count 0Fh.
        bus_start();
        send(8'hD2, 1, "R7 address");
        send(8'h03, 1, "R7 offset");
        bus_start();
        send(8'hD3, 1, "R2 read address");
        recv(0, 8'h0F, "R7 count byte");
        for (int i = 0; i < 15; i++) recv(i == 14, model[3+i], "R7 read data");
        bus_stop();

        // R2: foreign address is NACKed and the rest ignored.
        bus_start();
        send(8'hA4, 0, "R2 foreign address nack");
        send(8'h05, 0, "R2 ignored byte");
        bus_stop();
        chk(rv(5), model[5], "R2 register untouched");

        // R4: zero count rejected.
        bus_start();
        send(8'hD2, 1, "R4 address");
        send(8'h0A, 1, "R4 offset");
        send(8'h00, 0, "R4 zero count nack");
        send(8'h55, 0, "R4 trailing byte nack");
        bus_stop();
        chk(rv(10), 8'h00, "R4 no write");

        // R5: bytes beyond the count are refused.
        bus_start();
        send(8'hD2, 1, "R5 address");
        send(8'h0C, 1, "R5 offset");
        send(8'h02, 1, "R5 count");
        send(8'h11, 1, "R5 data1");
        send(8'h22, 1, "R5 data2");
        send(8'h33, 0, "R5 extra nack");
        bus_stop();
        model[12] = 8'h11; model[13] = 8'h22;
        chk(rv(12), 8'h11, "R5 first");
        chk(rv(13), 8'h22, "R5 second");
        chk(rv(14), 8'h00, "R5 extra not written");

        // R8: write wraps from 31 to 0.
        bus_start();
        send(8'hD2, 1, "R8 address");
        send(8'h1F, 1, "R8 offset");
        send(8'h02, 1, "R8 count");
        send(8'h5A, 1, "R8 data31");
        send(8'hA5, 1, "R8 data0");
        bus_stop();
        model[31] = 8'h5A; model[0] = 8'hA5;
        chk(rv(31), 8'h5A, "R8 write reg31");
        chk(rv(0), 8'hA5, "R8 write wrapped reg0");

        // R6: one-cycle read, count 83h sets register 8 to 3; R8 read wrap.
        bus_start();
        send(8'hD2, 1, "R6 address");
        send(8'h1F, 1, "R6 offset");
        send(8'h83, 1, "R6 count with bit7");
        model[8] = 8'h03;
        chk(rv(8), 8'h03, "R6 count register loaded");
        chk(rv(31), model[31], "R6 data not written");
        bus_start();
        send(8'hD3, 1, "R6 read address");
        recv(0, 8'h03, "R6 count returned");
        recv(0, model[31], "R8 read reg31");
        recv(0, model[0], "R8 read wrapped reg0");
        recv(1, model[1], "R8 read reg1");
        bus_stop();

        // R9: normal write to register 8 changes the read count.
        bus_start();
        send(8'hD2, 1, "R9 address");
        send(8'h08, 1, "R9 offset");
        send(8'h01, 1, "R9 count");
        send(8'h05, 1, "R9 data");
        bus_stop();
        model[8] = 8'h05;
        bus_start();
        send(8'hD2, 1, "R9 address2");
        send(8'h0C, 1, "R9 offset2");
        bus_start();
        send(8'hD3, 1, "R9 read address");
        recv(0, 8'h05, "R9 new count");
        for (int i = 0; i < 5; i++) recv(i == 4, model[12+i], "R9 read data");
        bus_stop();

        // R10: stop inside a data byte aborts without corrupting.
        bus_start();
        send(8'hD2, 1, "R10 address");
        send(8'h14, 1, "R10 offset");
        send(8'h02, 1, "R10 count");
        send(8'h77, 1, "R10 first byte");
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
        bus_stop();
        model[20] = 8'h77;
        chk(rv(20), 8'h77, "R10 committed byte kept");
        chk(rv(21), 8'h00, "R10 partial byte dropped");

        // R11: after host NACK the target stays released.
        bus_start();
        send(8'hD2, 1, "R11 address");
        send(8'h00, 1, "R11 offset");
        bus_start();
        send(8'hD3, 1, "R11 read address");
        recv(1, 8'h05, "R11 count then nack");
        recv(1, 8'hFF, "R11 bus released after nack");
        bus_stop();
        chk({7'd0, sda_oe}, 8'h00, "R11 idle released");

        // R12: enable never moved while SCL was high.
        chk(8'(oe_bad), 8'h00, "R12 enable change with SCL high");
        chk(8'(exp_q.size()), 8'h00, "scoreboard drained");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule